// File: doc/BRIEF.md
# Floating-Point Rename Register File

This block holds the floating-point register state of an out-of-order core. It has thirty-two 64-bit committed registers and a small circular pool of rename slots that hold speculative results. A dispatching instruction names its destination register and gets the next free slot automatically. The slot number it receives serves as the tag for the result. Operand lookups search the pool for the youngest slot bound to the requested register. A lookup that finds a slot whose result has not arrived returns the tag. A lookup that finds a slot holding a result returns that result. A lookup that finds no slot returns the committed register value.

Execution units write results into slots by tag. The completion logic asks to retire the oldest slot. When that slot holds its result, the value is copied into the committed register and the slot is freed. A flush empties the whole pool and leaves the committed registers untouched. Slots retire strictly in allocation order, at most one per cycle. Dispatch stalls while every slot is in use.

Top module: `fp_rename_file`

## Requirements
- R1: After reset every committed register reads as zero, no lookup hits the pool, and `disp_ready` is 1.
- R2: Each accepted dispatch (`disp_valid` and `disp_ready` both 1) returns in `disp_tag`, in the same cycle, the slot it takes. Slots are handed out as 0,1,...,5 and then wrap back to 0. The count starts at 0 after reset and after a flush.
- R3: While all six slots are in use, `disp_ready` is 0. A dispatch offered in that state is ignored: it takes no slot and does not advance the tag sequence.
- R4: A lookup of a register that has no pool slot returns the committed value, with `src_hit`=0 and `src_pend`=0.
- R5: A lookup that matches a slot still waiting for its result returns `src_hit`=1, `src_pend`=1, the slot number in `src_tag`, and all-zero data.
- R6: Once a slot has its result, a lookup that matches it returns the result with `src_hit`=1, `src_pend`=0 and the slot number in `src_tag`.
- R7: When several slots target the same register, the lookup returns the most recently allocated one.
- R8: `ret_ack` is 1 in a cycle with `ret_req`=1 exactly when the oldest slot holds its result. In that case the value reaches the committed register at the clock edge and the slot is freed. Otherwise nothing changes.
- R9: Retirement follows allocation order and takes at most one slot per cycle.
- R10: `flush` empties the pool at the next edge and leaves the committed registers unchanged. Flush takes priority over a dispatch, writeback or retire in the same cycle, so `ret_ack` is 0 in that cycle.
- R11: A writeback whose tag names a free slot is ignored. A slot allocated later starts out waiting for its result.
- R12: Lookups see state as it stood at the start of the cycle. A dispatch or writeback in the same cycle shows up only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all rename slots |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | 5 | Destination register of the dispatch |
| disp_ready | output | 1 | A slot is free |
| disp_tag | output | 3 | Slot given to the dispatch |
| wb_valid | input | 1 | Result write |
| wb_tag | input | 3 | Slot receiving the result |
| wb_data | input | 64 | Result value |
| ret_req | input | 1 | Request to retire the oldest slot |
| ret_ack | output | 1 | Oldest slot retired this cycle |
| src_idx | input | 2x5 | Register index per lookup port |
| src_data | output | 2x64 | Operand value per port |
| src_hit | output | 2 | Lookup matched a pool slot |
| src_pend | output | 2 | Matched slot still awaits its result |
| src_tag | output | 2x3 | Matched slot number |

## Verification
The collision of interest is a writeback and an operand lookup of the same slot in the same cycle. The bench writes a result into a slot while a lookup port is pointed at that slot's register. The lookup must still report the slot as pending, and the value must appear only in the following cycle. A second collision pairs a retire with a flush: the oldest slot is made ready first, then both requests are raised together. The bench checks that `ret_ack` stays low and that the register later reads its old committed value.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

   typedef enum logic [1:0] {
      SRC_ARCH  = 2'd0,
      SRC_PEND  = 2'd1,
      SRC_READY = 2'd2
   } src_kind_e;

endpackage

// File: rtl/fprf_arch.sv
module fprf_arch #(
   parameter int NUM_ARCH = 32,
   parameter int DATA_W   = 64,
   parameter int RD_PORTS = 2,
   localparam int AW      = $clog2(NUM_ARCH)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   input  logic [RD_PORTS-1:0][AW-1:0]    rd_idx,
   output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem_q [NUM_ARCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ARCH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wr_idx] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem_q[rd_idx[p]];
   end

   // R8: a commit lands in the committed file at the edge
   p_commit_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/fprf_pool.sv
module fprf_pool #(
   parameter int NUM_REN = 6,
   parameter int AW      = 5,
   parameter int DATA_W  = 64,
   localparam int TW     = $clog2(NUM_REN),
   localparam int CW     = $clog2(NUM_REN + 1)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            alloc_req,
   input  logic [AW-1:0]                   alloc_dest,
   output logic                            alloc_ok,
   output logic [TW-1:0]                   alloc_tag,
   input  logic                            wb_valid,
   input  logic [TW-1:0]                   wb_tag,
   input  logic [DATA_W-1:0]               wb_data,
   input  logic                            ret_req,
   output logic                            ret_fire,
   output logic [AW-1:0]                   ret_dest,
   output logic [DATA_W-1:0]               ret_data,
   output logic [NUM_REN-1:0]              ent_valid,
   output logic [NUM_REN-1:0]              ent_rdy,
   output logic [NUM_REN-1:0][AW-1:0]      ent_dest,
   output logic [NUM_REN-1:0][DATA_W-1:0]  ent_data,
   output logic [TW-1:0]                   head
);

   localparam logic [CW-1:0] FULL_CNT = CW'(NUM_REN);
   localparam logic [TW-1:0] LAST_TAG = TW'(NUM_REN - 1);
   localparam logic [TW:0]   REN_EXT  = (TW+1)'(NUM_REN);

   logic [NUM_REN-1:0]             valid_q, rdy_q;
   logic [NUM_REN-1:0][AW-1:0]     dest_q;
   logic [NUM_REN-1:0][DATA_W-1:0] data_q;
   logic [TW-1:0]                  head_q, head_nxt, tail;
   logic [CW-1:0]                  count_q;
   logic [TW:0]                    tail_sum;
   logic                           alloc_fire, wb_hit;

   assign tail_sum = {1'b0, head_q} + (TW+1)'(count_q);

   // variant picked by the pool size: natural wrap or explicit compare
   if ((NUM_REN & (NUM_REN - 1)) == 0) begin : g_pow2
      assign tail     = tail_sum[TW-1:0];
      assign head_nxt = head_q + 1'b1;
   end else begin : g_wrap
      assign tail     = (tail_sum >= REN_EXT) ? TW'(tail_sum - REN_EXT) : tail_sum[TW-1:0];
      assign head_nxt = (head_q == LAST_TAG) ? '0 : head_q + 1'b1;
   end

   assign alloc_ok   = (count_q != FULL_CNT);
   assign alloc_fire = alloc_req && alloc_ok && !flush;
   assign alloc_tag  = tail;
   assign wb_hit     = wb_valid && (wb_tag <= LAST_TAG) && valid_q[wb_tag];
   assign ret_fire   = ret_req && !flush && valid_q[head_q] && rdy_q[head_q];
   assign ret_dest   = dest_q[head_q];
   assign ret_data   = data_q[head_q];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         valid_q <= '0;
         rdy_q   <= '0;
         head_q  <= '0;
         count_q <= '0;
         if (!rst_n) begin
            dest_q <= '0;
            data_q <= '0;
         end
      end else begin
         if (wb_hit) begin
            rdy_q[wb_tag]  <= 1'b1;
            data_q[wb_tag] <= wb_data;
         end
         if (ret_fire) begin
            valid_q[head_q] <= 1'b0;
            rdy_q[head_q]   <= 1'b0;
            head_q          <= head_nxt;
         end
         if (alloc_fire) begin
            valid_q[tail] <= 1'b1;
            rdy_q[tail]   <= 1'b0;
            dest_q[tail]  <= alloc_dest;
         end
         count_q <= count_q + CW'(alloc_fire) - CW'(ret_fire);
      end
   end

   assign ent_valid = valid_q;
   assign ent_rdy   = rdy_q;
   assign ent_dest  = dest_q;
   assign ent_data  = data_q;
   assign head      = head_q;

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);

   p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));

   p_head_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> (head_q == $past(head_q)) || (head_q == $past(head_nxt)));

   p_retire_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ret_fire |=> !valid_q[$past(head_q)]);

   p_wb_free_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && (wb_tag <= LAST_TAG) && !valid_q[wb_tag]) |=> !rdy_q[$past(wb_tag)]);

endmodule

// File: rtl/fprf_lookup.sv
module fprf_lookup
   import fprf_pkg::*;
#(
   parameter int NUM_REN = 6,
   parameter int AW      = 5,
   parameter int DATA_W  = 64,
   localparam int TW     = $clog2(NUM_REN)
) (
   input  logic [AW-1:0]                   idx,
   input  logic [NUM_REN-1:0]              ent_valid,
   input  logic [NUM_REN-1:0]              ent_rdy,
   input  logic [NUM_REN-1:0][AW-1:0]      ent_dest,
   input  logic [NUM_REN-1:0][DATA_W-1:0]  ent_data,
   input  logic [TW-1:0]                   head,
   input  logic [DATA_W-1:0]               arch_data,
   output logic [DATA_W-1:0]               data,
   output logic                            hit,
   output logic                            pend,
   output logic [TW-1:0]                   tag
);

   src_kind_e kind;

   // scan oldest to youngest so the last match wins
   always_comb begin
      hit = 1'b0;
      tag = '0;
      for (int k = 0; k < NUM_REN; k++) begin
         int s;
         s = int'(head) + k;
         if (s >= NUM_REN) s = s - NUM_REN;
         if (ent_valid[s] && (ent_dest[s] == idx)) begin
            hit = 1'b1;
            tag = TW'(s);
         end
      end
   end

   always_comb begin
      if (!hit)              kind = SRC_ARCH;
      else if (ent_rdy[tag]) kind = SRC_READY;
      else                   kind = SRC_PEND;
   end

   always_comb begin
      case (kind)
         SRC_READY: data = ent_data[tag];
         SRC_PEND:  data = '0;
         default:   data = arch_data;
      endcase
   end

   assign pend = (kind == SRC_PEND);

endmodule

// File: rtl/fp_rename_file.sv
module fp_rename_file #(
   parameter int NUM_ARCH = 32,
   parameter int DATA_W   = 64,
   parameter int NUM_REN  = 6,
   parameter int RD_PORTS = 2,
   localparam int AW      = $clog2(NUM_ARCH),
   localparam int TW      = $clog2(NUM_REN)
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            flush,
   input  logic                            disp_valid,
   input  logic [AW-1:0]                   disp_dest,
   output logic                            disp_ready,
   output logic [TW-1:0]                   disp_tag,
   input  logic                            wb_valid,
   input  logic [TW-1:0]                   wb_tag,
   input  logic [DATA_W-1:0]               wb_data,
   input  logic                            ret_req,
   output logic                            ret_ack,
   input  logic [RD_PORTS-1:0][AW-1:0]     src_idx,
   output logic [RD_PORTS-1:0][DATA_W-1:0] src_data,
   output logic [RD_PORTS-1:0]             src_hit,
   output logic [RD_PORTS-1:0]             src_pend,
   output logic [RD_PORTS-1:0][TW-1:0]     src_tag
);

   initial begin
      assert (NUM_REN >= 2) else $error("rename pool needs at least two slots");
      assert (NUM_ARCH >= 2 && (NUM_ARCH & (NUM_ARCH - 1)) == 0)
         else $error("committed file size must be a power of two");
      assert (RD_PORTS >= 1 && DATA_W >= 1) else $error("bad port or width setting");
   end

   logic [NUM_REN-1:0]             ent_valid, ent_rdy;
   logic [NUM_REN-1:0][AW-1:0]     ent_dest;
   logic [NUM_REN-1:0][DATA_W-1:0] ent_data;
   logic [TW-1:0]                  head;
   logic [AW-1:0]                  ret_dest;
   logic [DATA_W-1:0]              ret_data;
   logic [RD_PORTS-1:0][DATA_W-1:0] arch_rd;

   fprf_arch #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_arch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ret_ack),
      .wr_idx  (ret_dest),
      .wr_data (ret_data),
      .rd_idx  (src_idx),
      .rd_data (arch_rd)
   );

   fprf_pool #(.NUM_REN(NUM_REN), .AW(AW), .DATA_W(DATA_W)) u_pool (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .alloc_req  (disp_valid),
      .alloc_dest (disp_dest),
      .alloc_ok   (disp_ready),
      .alloc_tag  (disp_tag),
      .wb_valid   (wb_valid),
      .wb_tag     (wb_tag),
      .wb_data    (wb_data),
      .ret_req    (ret_req),
      .ret_fire   (ret_ack),
      .ret_dest   (ret_dest),
      .ret_data   (ret_data),
      .ent_valid  (ent_valid),
      .ent_rdy    (ent_rdy),
      .ent_dest   (ent_dest),
      .ent_data   (ent_data),
      .head       (head)
   );

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
      fprf_lookup #(.NUM_REN(NUM_REN), .AW(AW), .DATA_W(DATA_W)) u_look (
         .idx       (src_idx[p]),
         .ent_valid (ent_valid),
         .ent_rdy   (ent_rdy),
         .ent_dest  (ent_dest),
         .ent_data  (ent_data),
         .head      (head),
         .arch_data (arch_rd[p]),
         .data      (src_data[p]),
         .hit       (src_hit[p]),
         .pend      (src_pend[p]),
         .tag       (src_tag[p])
      );
   end

endmodule

// File: tb/sim_fp_rename_file.sv
`timescale 1ns/1ps
module sim_fp_rename_file;

   localparam int S_DATA = 0, S_HIT = 1, S_PEND = 2, S_TAG = 3,
                  S_RDY = 4, S_DTAG = 5, S_ACK = 6;

   typedef struct {
      int          sel;
      int          port;
      logic [63:0] val;
      string       req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             flush = 1'b0;
   logic             disp_valid = 1'b0;
   logic [4:0]       disp_dest = '0;
   logic             disp_ready;
   logic [2:0]       disp_tag;
   logic             wb_valid = 1'b0;
   logic [2:0]       wb_tag = '0;
   logic [63:0]      wb_data = '0;
   logic             ret_req = 1'b0;
   logic             ret_ack;
   logic [1:0][4:0]  src_idx = '0;
   logic [1:0][63:0] src_data;
   logic [1:0]       src_hit, src_pend;
   logic [1:0][2:0]  src_tag;

   int   total = 0;
   int   bad = 0;
   bit   done = 1'b0;
   exp_t q[$];

   localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
   localparam logic [63:0] VB = 64'hB0B0_0B0B_CAFE_0001;
   localparam logic [63:0] VC = 64'hC3C3_5A5A_0000_0007;
   localparam logic [63:0] VE = 64'hEEEE_0000_1234_5678;
   localparam logic [63:0] VF = 64'hF00D_F00D_F00D_F00D;

   always #5 clk = ~clk;

   fp_rename_file u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .disp_valid(disp_valid), .disp_dest(disp_dest),
      .disp_ready(disp_ready), .disp_tag(disp_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .ret_req(ret_req), .ret_ack(ret_ack),
      .src_idx(src_idx), .src_data(src_data), .src_hit(src_hit),
      .src_pend(src_pend), .src_tag(src_tag)
   );

   task automatic expect_val(int sel, int port, logic [63:0] v, string req);
      exp_t e;
      e.sel = sel; e.port = port; e.val = v; e.req = req;
      q.push_back(e);
   endtask

   task automatic expect_src(int p, logic [63:0] d, bit h, bit pd, int t, string req);
      expect_val(S_DATA, p, d, req);
      expect_val(S_HIT,  p, 64'(h), req);
      expect_val(S_PEND, p, 64'(pd), req);
      if (h) expect_val(S_TAG, p, 64'(t), req);
   endtask

   // monitor: compare queued expectations away from the active edge
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t        e;
         logic [63:0] act;
         e = q.pop_front();
         case (e.sel)
            S_DATA:  act = src_data[e.port];
            S_HIT:   act = 64'(src_hit[e.port]);
            S_PEND:  act = 64'(src_pend[e.port]);
            S_TAG:   act = 64'(src_tag[e.port]);
            S_RDY:   act = 64'(disp_ready);
            S_DTAG:  act = 64'(disp_tag);
            default: act = 64'(ret_ack);
         endcase
         total++;
         if (act !== e.val) begin
            bad++;
            $display("FAIL %s sel=%0d port=%0d actual=%h expected=%h",
                     e.req, e.sel, e.port, act, e.val);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
      flush = 1'b0; disp_valid = 1'b0; wb_valid = 1'b0; ret_req = 1'b0;
   endtask

   task automatic dispatch(int d);
      disp_valid = 1'b1; disp_dest = 5'(d);
   endtask

   task automatic wback(int t, logic [63:0] v);
      wb_valid = 1'b1; wb_tag = 3'(t); wb_data = v;
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      // R1: reset state
      src_idx[0] = 5'd3; src_idx[1] = 5'd31;
      expect_src(0, 64'd0, 0, 0, 0, "R1");
      expect_src(1, 64'd0, 0, 0, 0, "R1");
      expect_val(S_RDY, 0, 64'd1, "R1");
      cyc();
      // step 1: first dispatch, same-cycle lookup misses (R12)
      dispatch(5); src_idx[0] = 5'd5;
      expect_val(S_DTAG, 0, 64'd0, "R2");
      expect_src(0, 64'd0, 0, 0, 0, "R12");
      cyc();
      // step 2
      dispatch(5); src_idx[0] = 5'd5;
      expect_val(S_DTAG, 0, 64'd1, "R2");
      expect_src(0, 64'd0, 1, 1, 0, "R5");
      cyc();
      // step 3
      wback(0, VA); dispatch(7); src_idx[0] = 5'd5; src_idx[1] = 5'd7;
      expect_val(S_DTAG, 0, 64'd2, "R2");
      expect_src(0, 64'd0, 1, 1, 1, "R7");
      expect_src(1, 64'd0, 0, 0, 0, "R12");
      cyc();
      // step 4: writeback and lookup of the same slot collide
      wback(1, VB); dispatch(9); src_idx[0] = 5'd5;
      expect_val(S_DTAG, 0, 64'd3, "R2");
      expect_src(0, 64'd0, 1, 1, 1, "R12");
      cyc();
      // step 5
      ret_req = 1'b1; dispatch(10); src_idx[0] = 5'd5;
      expect_val(S_DTAG, 0, 64'd4, "R2");
      expect_src(0, VB, 1, 0, 1, "R6");
      expect_val(S_ACK, 0, 64'd1, "R8");
      cyc();
      // step 6
      ret_req = 1'b1; dispatch(11); src_idx[0] = 5'd5; src_idx[1] = 5'd9;
      expect_val(S_DTAG, 0, 64'd5, "R2");
      expect_src(0, VB, 1, 0, 1, "R7");
      expect_src(1, 64'd0, 1, 1, 3, "R5");
      expect_val(S_ACK, 0, 64'd1, "R9");
      cyc();
      // step 7: oldest not ready, tag wraps
      ret_req = 1'b1; dispatch(12); src_idx[0] = 5'd5;
      expect_src(0, VB, 0, 0, 0, "R4");
      expect_val(S_ACK, 0, 64'd0, "R8");
      expect_val(S_DTAG, 0, 64'd0, "R2");
      cyc();
      // step 8: pool becomes full
      dispatch(13); src_idx[1] = 5'd12;
      expect_val(S_RDY, 0, 64'd1, "R3");
      expect_val(S_DTAG, 0, 64'd1, "R2");
      expect_src(1, 64'd0, 1, 1, 0, "R5");
      cyc();
      // step 9: full, dispatch offered and ignored
      dispatch(14); wback(2, VC); ret_req = 1'b1;
      expect_val(S_RDY, 0, 64'd0, "R3");
      expect_val(S_ACK, 0, 64'd0, "R12");
      cyc();
      // step 10
      ret_req = 1'b1; src_idx[0] = 5'd14; src_idx[1] = 5'd7;
      expect_val(S_RDY, 0, 64'd0, "R3");
      expect_src(0, 64'd0, 0, 0, 0, "R3");
      expect_src(1, VC, 1, 0, 2, "R6");
      expect_val(S_ACK, 0, 64'd1, "R9");
      cyc();
      // step 11
      dispatch(14); src_idx[0] = 5'd7;
      expect_val(S_RDY, 0, 64'd1, "R3");
      expect_val(S_DTAG, 0, 64'd2, "R3");
      expect_src(0, VC, 0, 0, 0, "R8");
      cyc();
      // step 12
      wback(3, VE);
      expect_val(S_RDY, 0, 64'd0, "R3");
      cyc();
      // step 13: flush and retire collide
      flush = 1'b1; ret_req = 1'b1; src_idx[0] = 5'd9;
      expect_val(S_ACK, 0, 64'd0, "R10");
      expect_src(0, VE, 1, 0, 3, "R6");
      cyc();
      // step 14
      wback(0, VF); src_idx[0] = 5'd9; src_idx[1] = 5'd5;
      expect_val(S_RDY, 0, 64'd1, "R10");
      expect_src(0, 64'd0, 0, 0, 0, "R10");
      expect_src(1, VB, 0, 0, 0, "R10");
      cyc();
      // step 15
      dispatch(20); src_idx[0] = 5'd12;
      expect_src(0, 64'd0, 0, 0, 0, "R11");
      expect_val(S_DTAG, 0, 64'd0, "R10");
      cyc();
      // step 16
      src_idx[0] = 5'd20;
      expect_src(0, 64'd0, 1, 1, 0, "R11");
      cyc();
      cyc();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule